// File: doc/BRIEF.md
# Parallel Flash Command Sequencer

This block is the command front end of a word-wide parallel NOR flash device. Bus writes arrive as chip-enable, write-enable, address and data strobes. A decoder recognises multi-cycle unlock sequences, which start word programs and sector erases. It also handles a bypass mode, where a program takes only two writes, and suspend and resume of a running operation. Each accepted operation drives a small behavioural word array. The array completes after a number of clock cycles set by a parameter.

While an operation runs, every read returns a status word instead of array data. Bit 7 carries the complement of the target's final bit 7, which is data-complement polling. Bit 6 flips on every read. The active-low ready output is held low. An erase can be suspended, and the host can then read other sectors and program them. A program can also be suspended, and the host can then read elsewhere. A single command resumes whichever operation is paused.

Top module: `flash_cmd_seq`

## Requirements
- R1: After reset, `ry_by_n` is 1, `rdata` is 0, every array word reads 0xFFFF and the decoder is in read-array mode.
- R2: The four writes 0xAA at address 0x555, 0x55 at 0x2AA, 0xA0 at 0x555, then a data word at the target program that word to old AND data, so bits are only cleared. The command addresses compare the low 11 address bits and command codes use data bits 7:0. An array word is selected by a sector (the top SEC_W address bits) and an offset (the low OFF_W bits).
- R3: The writes 0xAA at 0x555, 0x55 at 0x2AA, 0x20 at 0x555 enter bypass mode. In bypass mode, 0xA0 at any address followed by data at the target programs one word. Writing 0x90 then 0x00 leaves bypass mode, after which a lone 0xA0 plus data programs nothing.
- R4: While an operation runs, reads return a status word. Bits 7 and 15 hold the complement of bit 7 of the program data, or 0 during an erase. Every bit other than 15, 14, 7 and 6 is 0. After completion, reads return array data.
- R5: While an operation runs, bits 6 and 14 of the status word invert on each successive read. After completion, repeated reads of a word return the same value.
- R6: `ry_by_n` is 0 for exactly PROG_CYCLES clock cycles after the committing edge of a program, and ERASE_CYCLES cycles for an erase. Suspended time is not counted.
- R7: The six writes 0xAA at 0x555, 0x55 at 0x2AA, 0x80 at 0x555, 0xAA at 0x555, 0x55 at 0x2AA, then 0x30 at any address in a sector set every word of that sector to 0xFFFF on completion. Every other sector is left unchanged.
- R8: Writing 0xB0 while an erase runs suspends it, and `ry_by_n` rises. Other sectors can then be read and programmed, and the erased sector still holds its old data. Writing 0x30 in read mode resumes the erase for its remaining cycles.
- R9: Writing 0xB0 while a program runs (with no erase pending) suspends it, and the target keeps its old value. Writing 0x30 resumes the program for its remaining cycles.
- R10: Any write that breaks an expected sequence, or 0xF0, returns the decoder to read-array mode with the array unchanged. A program into the sector of a suspended erase is dropped.
- R11: While an operation runs, every write other than 0xB0 is ignored.
- R12: A write commits on the first clock edge where `we_n` is seen high after being low with `ce_n` low. A read is captured on the first edge where `oe_n` is low with `ce_n` low. `rdata` changes at that edge and then holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write strobe, active low |
| oe_n | input | 1 | Read strobe, active low |
| addr | input | ADDR_W | Word address |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data or status word |
| ry_by_n | output | 1 | Low while an operation runs |

## Verification
The hardest situation to reach is a program nested inside a suspended erase, followed by a resume whose remaining duration must come out exactly. The bench commits the erase and issues the suspend at once, so a known three cycles have elapsed. During the pause it programs another sector and also tries a program into the frozen sector, which must be dropped. It then resumes and counts low cycles on `ry_by_n` against ERASE_CYCLES minus three.

// File: rtl/flash_seq_pkg.sv
`timescale 1ns/1ps
package flash_seq_pkg;
    typedef enum logic [3:0] {
        SQ_READ, SQ_UL1, SQ_UL2, SQ_PROG, SQ_ER_SETUP,
        SQ_ER_UL1, SQ_ER_UL2, SQ_BYP, SQ_BYP_PROG, SQ_BYP_EXIT
    } seq_e;

    localparam logic [7:0] CMD_KEY_A     = 8'hAA;
    localparam logic [7:0] CMD_KEY_B     = 8'h55;
    localparam logic [7:0] CMD_PROGRAM   = 8'hA0;
    localparam logic [7:0] CMD_ER_ARM    = 8'h80;
    localparam logic [7:0] CMD_ER_SECTOR = 8'h30;
    localparam logic [7:0] CMD_BYP_ENTER = 8'h20;
    localparam logic [7:0] CMD_PAUSE     = 8'hB0;
    localparam logic [7:0] CMD_CONTINUE  = 8'h30;
    localparam logic [7:0] CMD_BYP_LEAVE = 8'h90;
    localparam logic [7:0] CMD_BYP_DONE  = 8'h00;

    localparam int          KEY_ADDR_W = 11;
    localparam logic [10:0] KEY_ADDR_A = 11'h555;
    localparam logic [10:0] KEY_ADDR_B = 11'h2AA;
endpackage

// File: rtl/flash_cmd_fsm.sv
`timescale 1ns/1ps
module flash_cmd_fsm
    import flash_seq_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int SEC_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_stb,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        cmd,
    input  logic              running,
    input  logic              prog_active,
    input  logic              erase_active,
    input  logic [SEC_W-1:0]  erase_sector,
    output logic              req_prog,
    output logic              req_erase,
    output logic              req_pause,
    output logic              req_continue
);
    seq_e st_d, st_q;

    logic [KEY_ADDR_W-1:0] key_a;
    logic [SEC_W-1:0]      wr_sec;
    logic                  paused_any;
    logic                  prog_ok;
    logic                  erase_ok;

    assign key_a      = wr_addr[KEY_ADDR_W-1:0];
    assign wr_sec     = wr_addr[ADDR_W-1 -: SEC_W];
    assign paused_any = !running && (prog_active || erase_active);
    // R10: no program into a sector whose erase is paused
    assign prog_ok    = !prog_active && !(erase_active && wr_sec == erase_sector);
    assign erase_ok   = !prog_active && !erase_active;

    always_comb begin
        st_d         = st_q;
        req_prog     = 1'b0;
        req_erase    = 1'b0;
        req_pause    = 1'b0;
        req_continue = 1'b0;
        if (wr_stb) begin
            if (running) begin
                // R11: only the pause command is heard while busy
                if (cmd == CMD_PAUSE) req_pause = 1'b1;
            end else begin
                case (st_q)
                    SQ_READ: begin
                        if (key_a == KEY_ADDR_A && cmd == CMD_KEY_A) st_d = SQ_UL1;
                        else if (cmd == CMD_CONTINUE && paused_any) req_continue = 1'b1;
                    end
                    SQ_UL1: st_d = (key_a == KEY_ADDR_B && cmd == CMD_KEY_B) ? SQ_UL2 : SQ_READ;
                    SQ_UL2: begin
                        st_d = SQ_READ;
                        if (key_a == KEY_ADDR_A) begin
                            if (cmd == CMD_PROGRAM) st_d = SQ_PROG;
                            else if (cmd == CMD_ER_ARM && erase_ok) st_d = SQ_ER_SETUP;
                            else if (cmd == CMD_BYP_ENTER) st_d = SQ_BYP;
                        end
                    end
                    SQ_PROG: begin
                        req_prog = prog_ok;
                        st_d     = SQ_READ;
                    end
                    SQ_ER_SETUP: st_d = (key_a == KEY_ADDR_A && cmd == CMD_KEY_A) ? SQ_ER_UL1 : SQ_READ;
                    SQ_ER_UL1:   st_d = (key_a == KEY_ADDR_B && cmd == CMD_KEY_B) ? SQ_ER_UL2 : SQ_READ;
                    SQ_ER_UL2: begin
                        req_erase = (cmd == CMD_ER_SECTOR);
                        st_d      = SQ_READ;
                    end
                    SQ_BYP: begin
                        if (cmd == CMD_PROGRAM) st_d = SQ_BYP_PROG;
                        else if (cmd == CMD_BYP_LEAVE) st_d = SQ_BYP_EXIT;
                        else if (cmd == CMD_CONTINUE && paused_any) req_continue = 1'b1;
                    end
                    SQ_BYP_PROG: begin
                        req_prog = prog_ok;
                        st_d     = SQ_BYP;
                    end
                    SQ_BYP_EXIT: st_d = (cmd == CMD_BYP_DONE) ? SQ_READ : SQ_BYP;
                    default:     st_d = SQ_READ;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= SQ_READ;
        else        st_q <= st_d;
    end

    // R11: the decoder is parked in an idle mode whenever an operation runs
    p_idle_while_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
        running |-> (st_q == SQ_READ || st_q == SQ_BYP))
        else $error("decoder left idle mode while busy");
endmodule

// File: rtl/flash_op_engine.sv
`timescale 1ns/1ps
module flash_op_engine #(
    parameter int IDX_W        = 6,
    parameter int SEC_W        = 2,
    parameter int DATA_W       = 16,
    parameter int PROG_CYCLES  = 8,
    parameter int ERASE_CYCLES = 40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_prog,
    input  logic              req_erase,
    input  logic              req_pause,
    input  logic              req_continue,
    input  logic [IDX_W-1:0]  req_idx,
    input  logic [DATA_W-1:0] req_data,
    input  logic [SEC_W-1:0]  req_sec,
    output logic              running,
    output logic              prog_active,
    output logic              erase_active,
    output logic [SEC_W-1:0]  erase_sector,
    output logic              poll_bit,
    output logic              arr_wr_en,
    output logic [IDX_W-1:0]  arr_wr_idx,
    output logic [DATA_W-1:0] arr_wr_data,
    output logic              arr_er_en,
    output logic [SEC_W-1:0]  arr_er_sec
);
    localparam int MAXC  = (PROG_CYCLES > ERASE_CYCLES) ? PROG_CYCLES : ERASE_CYCLES;
    localparam int CNT_W = $clog2(MAXC + 1);

    typedef struct packed {
        logic              p_act;
        logic              p_sus;
        logic [IDX_W-1:0]  p_idx;
        logic [DATA_W-1:0] p_data;
        logic [CNT_W-1:0]  p_cnt;
        logic              e_act;
        logic              e_sus;
        logic [SEC_W-1:0]  e_sec;
        logic [CNT_W-1:0]  e_cnt;
    } eng_s;

    eng_s eng_d, eng_q;
    logic prog_run, er_run;

    assign prog_run = eng_q.p_act && !eng_q.p_sus;
    // a nested program owns the array while the erase is paused
    assign er_run   = eng_q.e_act && !eng_q.e_sus && !eng_q.p_act;

    always_comb begin
        eng_d     = eng_q;
        arr_wr_en = 1'b0;
        arr_er_en = 1'b0;
        if (prog_run) begin
            if (eng_q.p_cnt == CNT_W'(1)) begin
                arr_wr_en   = 1'b1;
                eng_d.p_act = 1'b0;
            end else begin
                eng_d.p_cnt = eng_q.p_cnt - CNT_W'(1);
            end
        end
        if (er_run) begin
            if (eng_q.e_cnt == CNT_W'(1)) begin
                arr_er_en   = 1'b1;
                eng_d.e_act = 1'b0;
            end else begin
                eng_d.e_cnt = eng_q.e_cnt - CNT_W'(1);
            end
        end
        if (req_prog) begin
            eng_d.p_act  = 1'b1;
            eng_d.p_sus  = 1'b0;
            eng_d.p_idx  = req_idx;
            eng_d.p_data = req_data;
            eng_d.p_cnt  = CNT_W'(PROG_CYCLES);
        end
        if (req_erase) begin
            eng_d.e_act = 1'b1;
            eng_d.e_sus = 1'b0;
            eng_d.e_sec = req_sec;
            eng_d.e_cnt = CNT_W'(ERASE_CYCLES);
        end
        if (req_pause) begin
            if (prog_run && !eng_q.e_act) eng_d.p_sus = 1'b1;
            else if (er_run)              eng_d.e_sus = 1'b1;
        end
        if (req_continue) begin
            if (eng_q.p_act && eng_q.p_sus)      eng_d.p_sus = 1'b0;
            else if (eng_q.e_act && eng_q.e_sus) eng_d.e_sus = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) eng_q <= '0;
        else        eng_q <= eng_d;
    end

    assign running      = prog_run || er_run;
    assign prog_active  = eng_q.p_act;
    assign erase_active = eng_q.e_act;
    assign erase_sector = eng_q.e_sec;
    assign poll_bit     = prog_run ? ~eng_q.p_data[7] : 1'b0;
    assign arr_wr_idx   = eng_q.p_idx;
    assign arr_wr_data  = eng_q.p_data;
    assign arr_er_sec   = eng_q.e_sec;

    // R8: a paused erase keeps its remaining count
    p_erase_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_q.e_act && eng_q.e_sus) |=> eng_q.e_cnt == $past(eng_q.e_cnt))
        else $error("paused erase counter moved");

    // R6: the last running cycle of a program ends it
    p_prog_ends_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (prog_run && eng_q.p_cnt == CNT_W'(1) && !req_prog) |=> !eng_q.p_act)
        else $error("program outlived its count");

    // R9: a paused program does not count down
    p_prog_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_q.p_act && eng_q.p_sus) |=> eng_q.p_cnt == $past(eng_q.p_cnt))
        else $error("paused program counter moved");
endmodule

// File: rtl/flash_word_array.sv
`timescale 1ns/1ps
module flash_word_array #(
    parameter int SEC_W  = 2,
    parameter int OFF_W  = 4,
    parameter int DATA_W = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [SEC_W+OFF_W-1:0] wr_idx,
    input  logic [DATA_W-1:0]      wr_data,
    input  logic                   er_en,
    input  logic [SEC_W-1:0]       er_sec,
    input  logic [SEC_W+OFF_W-1:0] rd_idx,
    output logic [DATA_W-1:0]      rd_data
);
    localparam int IDX_W = SEC_W + OFF_W;
    localparam int WORDS = 1 << IDX_W;
    localparam int SPAN  = 1 << OFF_W;

    logic [DATA_W-1:0] mem_d [WORDS];
    logic [DATA_W-1:0] mem_q [WORDS];
    logic [DATA_W-1:0] wr_old;

    assign wr_old  = mem_q[wr_idx];
    assign rd_data = mem_q[rd_idx];

    always_comb begin
        for (int w = 0; w < WORDS; w++) begin
            mem_d[w] = mem_q[w];
            if (er_en && (w / SPAN) == int'(er_sec)) mem_d[w] = '1;
        end
        if (wr_en) mem_d[wr_idx] = wr_old & wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int w = 0; w < WORDS; w++) mem_q[w] <= '1;
        end else begin
            for (int w = 0; w < WORDS; w++) mem_q[w] <= mem_d[w];
        end
    end

    // R2: programming can only clear bits
    p_prog_and_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !er_en) |=> mem_q[$past(wr_idx)] == ($past(wr_old) & $past(wr_data)))
        else $error("program did not AND into the word");

    // R7: first word of an erased sector reads all ones
    p_erase_ones_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (er_en && !wr_en) |=> mem_q[{$past(er_sec), {OFF_W{1'b0}}}] == {DATA_W{1'b1}})
        else $error("erased word not all ones");
endmodule

// File: rtl/flash_cmd_seq.sv
`timescale 1ns/1ps
module flash_cmd_seq #(
    parameter int ADDR_W       = 12,
    parameter int DATA_W       = 16,
    parameter int SEC_W        = 2,
    parameter int OFF_W        = 4,
    parameter int PROG_CYCLES  = 8,
    parameter int ERASE_CYCLES = 40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              ry_by_n
);
    localparam int IDX_W = SEC_W + OFF_W;
    localparam int LANES = DATA_W / 8;

    typedef struct packed {
        logic              we_prev;
        logic              oe_prev;
        logic              tog;
        logic [DATA_W-1:0] rd;
    } bus_s;

    bus_s bus_d, bus_q;

    logic              wr_stb, rd_stb;
    logic [SEC_W-1:0]  a_sec;
    logic [IDX_W-1:0]  a_idx;
    logic              req_prog, req_erase, req_pause, req_continue;
    logic              running, prog_active, erase_active, poll_bit;
    logic [SEC_W-1:0]  erase_sector;
    logic              arr_wr_en, arr_er_en;
    logic [IDX_W-1:0]  arr_wr_idx;
    logic [DATA_W-1:0] arr_wr_data, arr_rd_data, status_word;
    logic [SEC_W-1:0]  arr_er_sec;

    // R12: strobe edges seen against the previous clock's levels
    assign wr_stb = !ce_n && we_n && !bus_q.we_prev;
    assign rd_stb = !ce_n && !oe_n && bus_q.oe_prev;
    assign a_sec  = addr[ADDR_W-1 -: SEC_W];
    assign a_idx  = {a_sec, addr[OFF_W-1:0]};

    flash_cmd_fsm #(.ADDR_W(ADDR_W), .SEC_W(SEC_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_addr(addr), .cmd(wdata[7:0]),
        .running(running), .prog_active(prog_active), .erase_active(erase_active),
        .erase_sector(erase_sector), .req_prog(req_prog), .req_erase(req_erase),
        .req_pause(req_pause), .req_continue(req_continue)
    );

    flash_op_engine #(
        .IDX_W(IDX_W), .SEC_W(SEC_W), .DATA_W(DATA_W),
        .PROG_CYCLES(PROG_CYCLES), .ERASE_CYCLES(ERASE_CYCLES)
    ) u_eng (
        .clk(clk), .rst_n(rst_n), .req_prog(req_prog), .req_erase(req_erase),
        .req_pause(req_pause), .req_continue(req_continue), .req_idx(a_idx),
        .req_data(wdata), .req_sec(a_sec), .running(running),
        .prog_active(prog_active), .erase_active(erase_active),
        .erase_sector(erase_sector), .poll_bit(poll_bit),
        .arr_wr_en(arr_wr_en), .arr_wr_idx(arr_wr_idx), .arr_wr_data(arr_wr_data),
        .arr_er_en(arr_er_en), .arr_er_sec(arr_er_sec)
    );

    flash_word_array #(.SEC_W(SEC_W), .OFF_W(OFF_W), .DATA_W(DATA_W)) u_arr (
        .clk(clk), .rst_n(rst_n), .wr_en(arr_wr_en), .wr_idx(arr_wr_idx),
        .wr_data(arr_wr_data), .er_en(arr_er_en), .er_sec(arr_er_sec),
        .rd_idx(a_idx), .rd_data(arr_rd_data)
    );

    // R4/R5: polling bit and toggle bit repeated in every byte lane
    always_comb begin
        status_word = '0;
        for (int b = 0; b < LANES; b++) begin
            status_word[b*8+7] = poll_bit;
            status_word[b*8+6] = bus_q.tog;
        end
    end

    always_comb begin
        bus_d         = bus_q;
        bus_d.we_prev = we_n;
        bus_d.oe_prev = oe_n;
        if (rd_stb) begin
            bus_d.rd = running ? status_word : arr_rd_data;
            if (running) bus_d.tog = ~bus_q.tog;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bus_q <= '{we_prev: 1'b1, oe_prev: 1'b1, tog: 1'b0, rd: '0};
        else        bus_q <= bus_d;
    end

    assign rdata   = bus_q.rd;
    assign ry_by_n = ~running;

    // R5: each read while busy flips the toggle state
    p_toggle_flip_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && running) |=> bus_q.tog != $past(bus_q.tog))
        else $error("toggle bit did not flip");

    // R12: read data holds between read strobes
    p_rdata_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_stb |=> $stable(rdata))
        else $error("rdata changed without a read");
endmodule

// File: tb/flash_cmd_seq_tb_top.sv
`timescale 1ns/1ps
module flash_cmd_seq_tb_top;
    localparam int P = 8;
    localparam int E = 40;
    localparam logic [1:0] OW = 2'd0, ORD = 2'd1, OD = 2'd2;

    typedef struct packed {
        logic [1:0]  op;
        logic [3:0]  req;
        logic [11:0] a;
        logic [15:0] d;
    } vec_t;

    localparam int NV = 58;
    localparam vec_t VEC [NV] = '{
        // R1 reset contents
        '{ORD, 4'd1, 12'h000, 16'hFFFF}, '{ORD, 4'd1, 12'hC0F, 16'hFFFF},
        // R2 four-cycle program, then AND-only reprogram
        '{OW, 4'd2, 12'h555, 16'h00AA}, '{OW, 4'd2, 12'h2AA, 16'h0055},
        '{OW, 4'd2, 12'h555, 16'h00A0}, '{OW, 4'd2, 12'h003, 16'h1234},
        '{OD, 4'd2, 12'h000, 16'h0000}, '{ORD, 4'd2, 12'h003, 16'h1234},
        '{OW, 4'd2, 12'h555, 16'h00AA}, '{OW, 4'd2, 12'h2AA, 16'h0055},
        '{OW, 4'd2, 12'h555, 16'h00A0}, '{OW, 4'd2, 12'h003, 16'hFF0F},
        '{OD, 4'd2, 12'h000, 16'h0000}, '{ORD, 4'd2, 12'h003, 16'h1204},
        // R10 broken sequence and reset command
        '{OW, 4'd10, 12'h555, 16'h00AA}, '{OW, 4'd10, 12'h123, 16'h0055},
        '{OW, 4'd10, 12'h555, 16'h00A0}, '{OW, 4'd10, 12'h004, 16'h0000},
        '{OD, 4'd10, 12'h000, 16'h0000}, '{ORD, 4'd10, 12'h004, 16'hFFFF},
        '{OW, 4'd10, 12'h555, 16'h00AA}, '{OW, 4'd10, 12'h2AA, 16'h0055},
        '{OW, 4'd10, 12'h555, 16'h00F0}, '{OW, 4'd10, 12'h005, 16'h0000},
        '{ORD, 4'd10, 12'h005, 16'hFFFF},
        // R3 bypass entry, two short programs, exit
        '{OW, 4'd3, 12'h555, 16'h00AA}, '{OW, 4'd3, 12'h2AA, 16'h0055},
        '{OW, 4'd3, 12'h555, 16'h0020}, '{OW, 4'd3, 12'h000, 16'h00A0},
        '{OW, 4'd3, 12'h801, 16'h5A5A}, '{OD, 4'd3, 12'h000, 16'h0000},
        '{OW, 4'd3, 12'h000, 16'h00A0}, '{OW, 4'd3, 12'h802, 16'h00FF},
        '{OD, 4'd3, 12'h000, 16'h0000}, '{ORD, 4'd3, 12'h801, 16'h5A5A},
        '{ORD, 4'd3, 12'h802, 16'h00FF}, '{OW, 4'd3, 12'h000, 16'h0090},
        '{OW, 4'd3, 12'h000, 16'h0000}, '{OW, 4'd3, 12'h000, 16'h00A0},
        '{OW, 4'd3, 12'h803, 16'h0000}, '{OD, 4'd3, 12'h000, 16'h0000},
        '{ORD, 4'd3, 12'h803, 16'hFFFF},
        // R7 sector erase leaves other sectors alone
        '{OW, 4'd7, 12'h555, 16'h00AA}, '{OW, 4'd7, 12'h2AA, 16'h0055},
        '{OW, 4'd7, 12'h555, 16'h00A0}, '{OW, 4'd7, 12'h400, 16'h1111},
        '{OD, 4'd7, 12'h000, 16'h0000}, '{ORD, 4'd7, 12'h400, 16'h1111},
        '{OW, 4'd7, 12'h555, 16'h00AA}, '{OW, 4'd7, 12'h2AA, 16'h0055},
        '{OW, 4'd7, 12'h555, 16'h0080}, '{OW, 4'd7, 12'h555, 16'h00AA},
        '{OW, 4'd7, 12'h2AA, 16'h0055}, '{OW, 4'd7, 12'h400, 16'h0030},
        '{OD, 4'd7, 12'h000, 16'h0000}, '{ORD, 4'd7, 12'h400, 16'hFFFF},
        '{ORD, 4'd7, 12'h003, 16'h1204}, '{ORD, 4'd7, 12'h801, 16'h5A5A}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
    logic [11:0] addr = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        ry_by_n;
    int          checks = 0, errors = 0;
    bit          done = 1'b0;

    always #10 clk = ~clk;

    flash_cmd_seq #(
        .ADDR_W(12), .DATA_W(16), .SEC_W(2), .OFF_W(4),
        .PROG_CYCLES(P), .ERASE_CYCLES(E)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
        .addr(addr), .wdata(wdata), .rdata(rdata), .ry_by_n(ry_by_n)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [11:0] a, input logic [15:0] d);
        @(negedge clk); ce_n = 1'b0; we_n = 1'b0; addr = a; wdata = d;
        @(negedge clk); we_n = 1'b1;
        @(negedge clk); ce_n = 1'b1;
    endtask

    task automatic bus_rd(input logic [11:0] a, output logic [15:0] d);
        @(negedge clk); ce_n = 1'b0; oe_n = 1'b0; addr = a;
        @(negedge clk); d = rdata; oe_n = 1'b1; ce_n = 1'b1;
    endtask

    task automatic full_prog(input logic [11:0] a, input logic [15:0] d);
        bus_wr(12'h555, 16'h00AA); bus_wr(12'h2AA, 16'h0055);
        bus_wr(12'h555, 16'h00A0); bus_wr(a, d);
    endtask

    task automatic full_erase(input logic [11:0] a);
        bus_wr(12'h555, 16'h00AA); bus_wr(12'h2AA, 16'h0055); bus_wr(12'h555, 16'h0080);
        bus_wr(12'h555, 16'h00AA); bus_wr(12'h2AA, 16'h0055); bus_wr(a, 16'h0030);
    endtask

    task automatic wait_ready(output int n);
        n = 0;
        while (ry_by_n == 1'b0) begin
            @(negedge clk);
            n++;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [15:0] r1, r2;
        int n;
        repeat (3) @(negedge clk);
        // R1 reset state at the ports
        chk("R1 ry_by_n", {15'd0, ry_by_n}, 16'h0001);
        chk("R1 rdata", rdata, 16'h0000);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            case (VEC[i].op)
                OW: bus_wr(VEC[i].a, VEC[i].d);
                ORD: begin
                    bus_rd(VEC[i].a, r1);
                    chk($sformatf("R%0d table[%0d]", VEC[i].req, i), r1, VEC[i].d);
                end
                default: wait_ready(n);
            endcase
        end

        // R4 R5: polling and toggle while a program runs, then true data
        full_prog(12'h006, 16'h0055);
        chk("R6 busy after commit", {15'd0, ry_by_n}, 16'h0000);
        bus_rd(12'h006, r1);
        bus_rd(12'h006, r2);
        chk("R4 poll bits", {r1[15], r1[7]}, 16'h0003);
        chk("R4 other bits zero", r1 & 16'h3F3F, 16'h0000);
        chk("R5 toggle differs", {15'd0, r1[6] ^ r2[6]}, 16'h0001);
        chk("R5 lanes agree", {15'd0, r1[14] ^ r1[6]}, 16'h0000);
        wait_ready(n);
        bus_rd(12'h006, r1);
        bus_rd(12'h006, r2);
        chk("R4 true data", r1, 16'h0055);
        chk("R5 stable after done", r2, 16'h0055);

        // R6: exact busy length of a program
        full_prog(12'h007, 16'h00F0);
        wait_ready(n);
        chk("R6 program cycles", 16'(n), 16'(P));
        bus_rd(12'h007, r1);
        chk("R2 result", r1, 16'h00F0);

        // R11: a full program sequence during an erase is ignored; R4 erase poll
        full_erase(12'hC00);
        bus_rd(12'hC05, r1);
        chk("R4 erase poll bit", {15'd0, r1[7]}, 16'h0000);
        full_prog(12'h00A, 16'h0000);
        wait_ready(n);
        bus_rd(12'h00A, r1);
        chk("R11 ignored program", r1, 16'hFFFF);

        // R8: erase suspend with nested program, blocked program, resume
        full_prog(12'h40C, 16'h0F0F);
        wait_ready(n);
        full_erase(12'h400);
        bus_wr(12'h000, 16'h00B0);
        chk("R8 ready when paused", {15'd0, ry_by_n}, 16'h0001);
        bus_rd(12'h003, r1);
        chk("R8 read other sector", r1, 16'h1204);
        bus_rd(12'h40C, r1);
        chk("R8 paused sector intact", r1, 16'h0F0F);
        full_prog(12'h80E, 16'h3333);
        chk("R8 nested program busy", {15'd0, ry_by_n}, 16'h0000);
        wait_ready(n);
        bus_rd(12'h80E, r1);
        chk("R8 nested program data", r1, 16'h3333);
        full_prog(12'h401, 16'h0000);
        chk("R10 blocked program stays ready", {15'd0, ry_by_n}, 16'h0001);
        bus_wr(12'h000, 16'h0030);
        chk("R8 busy after resume", {15'd0, ry_by_n}, 16'h0000);
        wait_ready(n);
        chk("R8 remaining erase cycles", 16'(n), 16'(E - 3));
        bus_rd(12'h40C, r1);
        chk("R8 erase finished", r1, 16'hFFFF);
        bus_rd(12'h401, r1);
        chk("R10 blocked word", r1, 16'hFFFF);
        bus_rd(12'h80E, r1);
        chk("R7 other sector kept", r1, 16'h3333);

        // R9: program suspend and resume
        full_prog(12'h808, 16'h0000);
        bus_wr(12'h000, 16'h00B0);
        chk("R9 ready when paused", {15'd0, ry_by_n}, 16'h0001);
        bus_rd(12'h808, r1);
        chk("R9 target still old", r1, 16'hFFFF);
        bus_rd(12'h003, r1);
        chk("R9 read other sector", r1, 16'h1204);
        bus_wr(12'h000, 16'h0030);
        wait_ready(n);
        chk("R9 remaining program cycles", 16'(n), 16'(P - 3));
        bus_rd(12'h808, r1);
        chk("R9 program finished", r1, 16'h0000);

        // R12: rdata holds after a read ends
        bus_rd(12'h003, r1);
        repeat (4) @(negedge clk);
        chk("R12 rdata held", rdata, 16'h1204);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule